// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block drives and samples a bank of 32 general-purpose pins from a simple synchronous register bus. Software sets each pin's output level and its direction (output or input) through four 16-bit registers. Two of them hold output levels and two hold directions, one of each for the low sixteen pins and one for the high sixteen. Every write to one of these registers carries a per-bit enable in its upper half. A single pin can therefore change without first reading the register back and merging the new value in.

The level on each pin is passed through a two-stage synchronizer and can be read as one 32-bit word. A read-only identifier at a fixed offset returns a nonzero constant, which lets software detect this split, masked register layout. The bus has no wait states. Writes take effect at the clock edge on which `we_i` is high, and `rdata_o` follows `addr_i` combinationally.

Top module: `gpio_bank`

## Requirements
- R1: After reset every output-level and direction bit is 0, so `pin_oe_o` and `pin_o` are all zero and every pin is an input.
- R2: A write to offset 0x00 updates the output levels of pins 0 to 15. Bit k of the data half (15:0) is applied to pin k.
- R3: A write to offset 0x04 updates the output levels of pins 16 to 31. Pin n is controlled by bit n-16 of that register.
- R4: Offsets 0x08 (pins 0 to 15) and 0x0C (pins 16 to 31) hold direction bits, where 1 means output and 0 means input. `pin_oe_o[n]` equals pin n's direction bit.
- R5: In a write to any of the four split registers, bit 16+k enables bit k. Bits whose enable is 0 keep their old value, and bits whose enable is 1 take the written value.
- R6: Reading a split register returns its 16 stored bits in 15:0 and zero in 31:16.
- R7: Reading offset 0x70 returns the 32 pin input levels as they were sampled two rising clock edges earlier.
- R8: Offset 0x78 reads as the constant 32'h0101_0000, and writes to it have no effect.
- R9: Writes to 0x70 or to any unmapped offset change no state, and reads from unmapped offsets return 0.
- R10: `pin_o[n]` equals pin n's stored output-level bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte offset of the register being accessed |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 32 | Write data; bits 31:16 enable bits 15:0 for split registers |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pin_i | input | 32 | Pin levels from the pads, asynchronous |
| pin_o | output | 32 | Output level for each pin |
| pin_oe_o | output | 32 | Output enable for each pin |

## Verification
The assertions assume that `addr_i`, `we_i` and `wdata_i` are stable around each rising edge. They also assume that `pin_i` is free to change at any time, because the synchronizer property only compares against values seen at earlier edges. The bench changes every input one nanosecond after the rising edge and samples the outputs at the falling edge, so no input ever moves at a sampling edge. Pin inputs are changed in the same way, which keeps the two-edge latency of the input register exact.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned N_SPLIT = 4;

  // split register order matches offsets 0x00, 0x04, 0x08, 0x0C
  typedef enum logic [1:0] {
    SEL_LVL_LO = 2'd0,
    SEL_LVL_HI = 2'd1,
    SEL_DIR_LO = 2'd2,
    SEL_DIR_HI = 2'd3
  } split_sel_e;

  localparam logic [ADDR_W-1:0] OFS_SPLIT_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IN_LVL     = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_LAYOUT_ID  = 8'h78;
endpackage

// File: rtl/gpio_mask_reg.sv
`timescale 1ns/1ps
module gpio_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [2*W-1:0] wdata_i,
  output logic [W-1:0]   q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] en;
  logic [W-1:0] val;

  assign en  = wdata_i[2*W-1:W];
  assign val = wdata_i[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_r <= '0;
    else if (wr_i) q_r <= (q_r & ~en) | (val & en);
  end

  assign q_o = q_r;

  // R5
  masked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o ^ $past(q_o)) & ~$past(wdata_i[2*W-1:W])) == '0);

  // R5
  enabled_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o ^ $past(wdata_i[W-1:0])) & $past(wdata_i[2*W-1:W])) == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // edges since reset, saturating; gates the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end

  // R7
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> sync_o == $past(pin_i, 2));
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS      = 32,
  parameter logic [31:0] LAYOUT_ID  = 32'h0101_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o
);
  localparam int unsigned HW = NPINS / 2;

  logic [HW-1:0]    split_q [N_SPLIT];
  logic [NPINS-1:0] in_sync;
  logic             split_hit;
  logic [1:0]       split_idx;

  assign split_hit = (addr_i[ADDR_W-1:4] == OFS_SPLIT_BASE[ADDR_W-1:4]) &&
                     (addr_i[1:0] == 2'b00);
  assign split_idx = addr_i[3:2];

  for (genvar g = 0; g < N_SPLIT; g++) begin : g_split
    gpio_mask_reg #(.W(HW)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && split_hit && (split_idx == 2'(g))),
      .wdata_i (wdata_i[2*HW-1:0]),
      .q_o     (split_q[g])
    );
  end

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (in_sync)
  );

  assign pin_o    = {split_q[SEL_LVL_HI], split_q[SEL_LVL_LO]};
  assign pin_oe_o = {split_q[SEL_DIR_HI], split_q[SEL_DIR_LO]};

  always_comb begin
    rdata_o = '0;
    if (split_hit)                  rdata_o[HW-1:0] = split_q[split_idx];
    else if (addr_i == OFS_IN_LVL)    rdata_o = in_sync;
    else if (addr_i == OFS_LAYOUT_ID) rdata_o = LAYOUT_ID;
  end

  // R6
  split_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:4] == 4'h0 && addr_i[1:0] == 2'b00) |-> rdata_o[31:16] == 16'h0);

  // R8
  layout_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_LAYOUT_ID) |-> rdata_o != 32'h0);

  // R9
  stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !split_hit) |=> ($stable(pin_o) && $stable(pin_oe_o)));
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  // behavioural reference
  logic [31:0] m_lvl, m_dir;
  logic [31:0] m_pin_hist [$];

  function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] w);
    logic [15:0] r;
    r = old;
    for (int b = 0; b < 16; b++) if (w[16+b]) r[b] = w[b];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = '0; m_dir = '0;
      m_pin_hist = '{32'h0, 32'h0};
    end else begin
      if (we) begin
        case (addr)
          8'h00: m_lvl[15:0]  = merge(m_lvl[15:0],  wdata);
          8'h04: m_lvl[31:16] = merge(m_lvl[31:16], wdata);
          8'h08: m_dir[15:0]  = merge(m_dir[15:0],  wdata);
          8'h0C: m_dir[31:16] = merge(m_dir[31:16], wdata);
          default: ;
        endcase
      end
      m_pin_hist.push_back(pin_in);
      void'(m_pin_hist.pop_front());
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return {16'h0, m_lvl[15:0]};
      8'h04: return {16'h0, m_lvl[31:16]};
      8'h08: return {16'h0, m_dir[15:0]};
      8'h0C: return {16'h0, m_dir[31:16]};
      8'h70: return m_pin_hist[0];
      8'h78: return 32'h0101_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(logic [7:0] a);
    case (a)
      8'h00: return "R2/R6";
      8'h04: return "R3/R6";
      8'h08, 8'h0C: return "R4/R6";
      8'h70: return "R7";
      8'h78: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10", pin_out, m_lvl);
      check("R4", pin_oe, m_dir);
      check(rd_tag(addr), rdata, exp_rd(addr));
    end
  end

  task automatic drive(logic [7:0] a, logic w, logic [31:0] d);
    @(posedge clk); #1;
    addr = a; we = w; wdata = d;
  endtask

  task automatic idle_read(logic [7:0] a);
    drive(a, 1'b0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", pin_out, 32'h0);
    check("R1", pin_oe, 32'h0);
    for (int a = 0; a < 16; a += 4) idle_read(8'(a));
    // R2 full-mask write then partial clear
    drive(8'h00, 1'b1, 32'hFFFF_A5A5);
    drive(8'h00, 1'b1, 32'h00F0_0000);
    idle_read(8'h00);
    @(negedge clk); check("R5", pin_out, 32'h0000_A505);
    // R5 zero enable changes nothing
    drive(8'h00, 1'b1, 32'h0000_FFFF);
    idle_read(8'h00);
    @(negedge clk); check("R5", pin_out, 32'h0000_A505);
    // R3 pin 31 and pin 16 via high half
    drive(8'h04, 1'b1, 32'h8001_FFFF);
    idle_read(8'h04);
    @(negedge clk); check("R3", pin_out, 32'h8001_A505);
    // R4 directions
    drive(8'h08, 1'b1, 32'h0F0F_FFFF);
    drive(8'h0C, 1'b1, 32'hFFFF_1234);
    idle_read(8'h0C);
    @(negedge clk); check("R4", pin_oe, 32'h1234_0F0F);
    // R6 upper half of readback zero despite set bits written
    idle_read(8'h08);
    @(negedge clk); check("R6", rdata, 32'h0000_0F0F);
    // R8 / R9 writes ignored
    drive(8'h78, 1'b1, 32'hFFFF_FFFF);
    drive(8'h70, 1'b1, 32'hFFFF_FFFF);
    drive(8'h40, 1'b1, 32'hFFFF_0000);
    drive(8'h02, 1'b1, 32'hFFFF_0000);
    idle_read(8'h78);
    @(negedge clk); check("R9", pin_out, 32'h8001_A505);
    check("R8", rdata, 32'h0101_0000);
    idle_read(8'h44);
    @(negedge clk); check("R9", rdata, 32'h0);
    // R7 input latency
    @(posedge clk); #1; pin_in = 32'hDEAD_BEEF; addr = 8'h70;
    @(negedge clk); check("R7", rdata, 32'h0);
    @(negedge clk); check("R7", rdata, 32'h0);
    @(negedge clk); check("R7", rdata, 32'hDEAD_BEEF);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 7))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h70; 5: a = 8'h78; 6: a = 8'h10;
        default: a = 8'(($urandom_range(0, 63)) * 4);
      endcase
      drive(a, 1'($urandom_range(0, 1)), $urandom());
      pin_in = $urandom();
    end
    idle_read(8'h00);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule